// File: doc/BRIEF.md
# Fast A20 Gate Command Decoder

This block watches the stream of host writes into a host-interface data channel and drives the gate A20 output without any help from a local processor. Every host write brings a byte, a channel number and a flag that marks the byte as a command or as data. When a command byte equal to 0xD1 arrives on the decoded channel, the decoder arms. The next data byte on that channel then sets the gate level from its bit 1. The register update happens on the clock edge that accepts the write, so the new level shows one cycle later.

Host writes use a valid/ready handshake. A write is accepted on a rising edge where both `wr_valid` and `wr_ready` are high. The decoder never applies back-pressure: `wr_ready` is high whenever reset is released. A sender may therefore hold `wr_valid` high for any number of cycles, and each such cycle counts as a separate write.

An enable input turns the fast path on. While the enable is low, the gate is held at 1 and the decoder stays idle. As a result, the first level seen once fast gating starts is always 1. A status output carries a copy of the gate level for the local processor to read.

Top module: `fast_a20_gate`

## Requirements
- R1: `wr_ready` is 0 while `rst_n` is low and 1 at all other times.
- R2: When the decoder is armed and the enable is high, an accepted data write (`wr_is_cmd`=0) on channel 0 sets `gate_a20` to bit 1 of `wr_data` from the next cycle onward.
- R3: Writes on any channel other than channel 0 change neither the gate level nor the arming.
- R4: After reset, and in every cycle after a cycle in which `fast_en` is 0, `gate_a20` is 1 and the decoder is idle.
- R5: An accepted data write on channel 0 while the decoder is idle leaves `gate_a20` unchanged.
- R6: An accepted command write of 0xD1 on channel 0 arms the decoder. Another 0xD1 received while already armed keeps it armed.
- R7: An accepted command write on channel 0 with any value other than 0xD1 returns the decoder to idle, and the gate does not change.
- R8: `gate_status` always equals `gate_a20`.
- R9: A data write that updates the gate also disarms the decoder, so a second data byte without a fresh 0xD1 leaves the gate unchanged.
- R10: A cycle with `wr_valid` low has no effect on the gate or on the arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_en | input | 1 | Fast gate enable; 0 holds the gate at 1 |
| wr_valid | input | 1 | Host write present |
| wr_ready | output | 1 | Write accepted when high together with valid |
| wr_chan | input | CHAN_W (2) | Host-interface channel number of the write |
| wr_is_cmd | input | 1 | 1 = command byte, 0 = data byte |
| wr_data | input | DATA_W (8) | Byte written by the host |
| gate_a20 | output | 1 | Gate A20 level |
| gate_status | output | 1 | Readable copy of the gate level |

## Verification
Directed sequences pair 0xD1 with data bytes whose bit 1 is set or clear. This shows the level really follows bit 1 and not some other bit. Further cases place the data byte after a different command, after a repeated 0xD1, after an earlier data byte, after a write on another channel, or after a cycle with valid low. Each of these tells arming, disarming and ignored writes apart. Random mixes of channels, flags, bytes (with 0xD1 weighted up) and enable drops are compared each cycle against a bench model. Toggling the enable checks that the gate is forced high and that an arming made before the drop is forgotten.

// File: rtl/a20_pkg.sv
package a20_pkg;
  typedef enum logic {
    ARM_IDLE  = 1'b0,
    ARM_WAIT  = 1'b1
  } arm_state_e;

  // One decoded host write, reduced to what the sequencer needs.
  typedef struct packed {
    logic hit;      // accepted write on the decoded channel
    logic trig;     // command equal to the trigger code
    logic other;    // any other command
    logic data;     // data byte
    logic level;    // selected bit of the byte
  } wr_event_s;
endpackage

// File: rtl/a20_wr_classify.sv
module a20_wr_classify
  import a20_pkg::*;
#(
  parameter int              CHAN_W      = 2,
  parameter int              DATA_W      = 8,
  parameter int              DECODE_CHAN = 0,
  parameter logic [7:0]      TRIG_CODE   = 8'hD1,
  parameter int              LEVEL_BIT   = 1
) (
  input  logic              wr_valid,
  input  logic              wr_ready,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              wr_is_cmd,
  input  logic [DATA_W-1:0] wr_data,
  output wr_event_s         ev
);
  localparam logic [CHAN_W-1:0] CHAN_SEL = CHAN_W'(DECODE_CHAN);
  localparam logic [DATA_W-1:0] TRIG_W   = DATA_W'(TRIG_CODE);

  logic accept;
  logic on_chan;
  logic code_match;

  assign accept     = wr_valid & wr_ready;
  assign on_chan    = (wr_chan == CHAN_SEL);
  assign code_match = (wr_data == TRIG_W);

  always_comb begin
    ev       = '0;
    ev.hit   = accept & on_chan;
    ev.trig  = ev.hit & wr_is_cmd & code_match;
    ev.other = ev.hit & wr_is_cmd & ~code_match;
    ev.data  = ev.hit & ~wr_is_cmd;
    ev.level = wr_data[LEVEL_BIT];
  end
endmodule

// File: rtl/a20_arm_fsm.sv
module a20_arm_fsm
  import a20_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fast_en,
  input  wr_event_s ev,
  output logic      armed,
  output logic      load
);
  arm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!fast_en) begin
      state_d = ARM_IDLE;
    end else if (ev.trig) begin
      state_d = ARM_WAIT;
    end else if (ev.other || ev.data) begin
      state_d = ARM_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ARM_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == ARM_WAIT);
  assign load  = fast_en & armed & ev.data;
endmodule

// File: rtl/a20_gate_reg.sv
module a20_gate_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_en,
  input  logic load,
  input  logic level,
  output logic gate
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !fast_en) gate_q <= 1'b1;
    else if (load)          gate_q <= level;
  end

  assign gate = gate_q;
endmodule

// File: rtl/fast_a20_gate.sv
module fast_a20_gate
  import a20_pkg::*;
#(
  parameter int         CHAN_W      = 2,
  parameter int         DATA_W      = 8,
  parameter int         DECODE_CHAN = 0,
  parameter logic [7:0] TRIG_CODE   = 8'hD1,
  parameter int         LEVEL_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              wr_is_cmd,
  input  logic [DATA_W-1:0] wr_data,
  output logic              gate_a20,
  output logic              gate_status
);
  wr_event_s ev;
  logic      armed;
  logic      load;
  logic      gate;

  assign wr_ready = rst_n;

  a20_wr_classify #(
    .CHAN_W(CHAN_W), .DATA_W(DATA_W), .DECODE_CHAN(DECODE_CHAN),
    .TRIG_CODE(TRIG_CODE), .LEVEL_BIT(LEVEL_BIT)
  ) u_classify (
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_chan(wr_chan),
    .wr_is_cmd(wr_is_cmd), .wr_data(wr_data), .ev(ev)
  );

  a20_arm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .ev(ev),
    .armed(armed), .load(load)
  );

  a20_gate_reg u_gate (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .load(load),
    .level(ev.level), .gate(gate)
  );

  assign gate_a20    = gate;
  assign gate_status = gate;
endmodule

// File: rtl/a20_gate_chk.sv
module a20_gate_chk #(
  parameter int         CHAN_W      = 2,
  parameter int         DATA_W      = 8,
  parameter int         DECODE_CHAN = 0,
  parameter logic [7:0] TRIG_CODE   = 8'hD1,
  parameter int         LEVEL_BIT   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fast_en,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [CHAN_W-1:0] wr_chan,
  input logic              wr_is_cmd,
  input logic [DATA_W-1:0] wr_data,
  input logic              gate_a20,
  input logic              gate_status,
  input logic              armed
);
  localparam logic [CHAN_W-1:0] CHAN_SEL = CHAN_W'(DECODE_CHAN);
  localparam logic [DATA_W-1:0] TRIG_W   = DATA_W'(TRIG_CODE);

  logic on_sel;
  assign on_sel = wr_valid && wr_ready && (wr_chan == CHAN_SEL);

  always_comb begin
    AST_READY_RESET: assert (wr_ready == rst_n); // R1
  end

  AST_ARMED_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && $past(fast_en) && $past(on_sel && wr_is_cmd && wr_data == TRIG_W)
     && on_sel && !wr_is_cmd)
    |=> (gate_a20 == $past(wr_data[LEVEL_BIT]))); // R2

  AST_OTHER_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && wr_valid && wr_chan != CHAN_SEL) |=> ($stable(gate_a20) && $stable(armed))); // R3

  AST_DISABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |=> (gate_a20 && !armed)); // R4

  AST_IDLE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && !armed && on_sel && !wr_is_cmd) |=> $stable(gate_a20)); // R5

  AST_TRIG_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && on_sel && wr_is_cmd && wr_data == TRIG_W) |=> armed); // R6

  AST_OTHER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && on_sel && wr_is_cmd && wr_data != TRIG_W) |=> (!armed && $stable(gate_a20))); // R7

  AST_STATUS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    gate_status == gate_a20); // R8

  AST_DATA_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (on_sel && !wr_is_cmd) |=> !armed); // R9

  AST_IDLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && !wr_valid) |=> ($stable(gate_a20) && $stable(armed))); // R10
endmodule

bind fast_a20_gate a20_gate_chk #(
  .CHAN_W(CHAN_W), .DATA_W(DATA_W), .DECODE_CHAN(DECODE_CHAN),
  .TRIG_CODE(TRIG_CODE), .LEVEL_BIT(LEVEL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_chan(wr_chan), .wr_is_cmd(wr_is_cmd),
  .wr_data(wr_data), .gate_a20(gate_a20), .gate_status(gate_status),
  .armed(armed)
);

// File: tb/sim_fast_a20_gate.sv
module sim_fast_a20_gate;
  localparam int CLK_PERIOD = 10;
  localparam int CHAN_W = 2;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fast_en = 1'b0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [CHAN_W-1:0] wr_chan = '0;
  logic              wr_is_cmd = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              gate_a20;
  logic              gate_status;

  int n_checks = 0;
  int n_fail   = 0;
  logic m_gate  = 1'b1;
  logic m_armed = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fast_a20_gate u0 (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_chan(wr_chan), .wr_is_cmd(wr_is_cmd),
    .wr_data(wr_data), .gate_a20(gate_a20), .gate_status(gate_status)
  );

  // Bench model of the next gate level, written from the requirements.
  function automatic logic next_gate(logic g, logic a, logic en, logic v,
                                     logic [CHAN_W-1:0] ch, logic c, logic [7:0] d);
    if (!en) return 1'b1;
    if (v && ch == 0 && !c && a) return d[1];
    return g;
  endfunction

  function automatic logic next_armed(logic a, logic en, logic v,
                                      logic [CHAN_W-1:0] ch, logic c, logic [7:0] d);
    if (!en) return 1'b0;
    if (!(v && ch == 0)) return a;
    if (c) return (d == 8'hD1);
    return 1'b0;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle after a falling edge, update the model at the rising
  // edge, compare at the next falling edge.
  task automatic cyc(string tag, logic en, logic v, logic [CHAN_W-1:0] ch,
                     logic c, logic [7:0] d);
    fast_en = en; wr_valid = v; wr_chan = ch; wr_is_cmd = c; wr_data = d;
    @(posedge clk);
    m_gate  = next_gate(m_gate, m_armed, en, v, ch, c, d);
    m_armed = next_armed(m_armed, en, v, ch, c, d);
    @(negedge clk);
    check(tag, gate_a20, m_gate);
    check("R8", gate_status, gate_a20);
    check("R1", wr_ready, 1'b1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    check("R1", wr_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4", gate_a20, 1'b1);
    check("R8", gate_status, 1'b1);

    // R2: arm, then clear and set via bit 1
    cyc("R4", 1'b1, 1'b0, 2'd0, 1'b0, 8'h00);
    cyc("R6", 1'b1, 1'b1, 2'd0, 1'b1, 8'hD1);
    cyc("R2", 1'b1, 1'b1, 2'd0, 1'b0, 8'hFD);
    check("R2", gate_a20, 1'b0);
    cyc("R6", 1'b1, 1'b1, 2'd0, 1'b1, 8'hD1);
    cyc("R2", 1'b1, 1'b1, 2'd0, 1'b0, 8'h02);
    check("R2", gate_a20, 1'b1);
    // R9: second data byte without re-arm
    cyc("R9", 1'b1, 1'b1, 2'd0, 1'b0, 8'h00);
    check("R9", gate_a20, 1'b1);
    // R5: data while idle
    cyc("R5", 1'b1, 1'b1, 2'd0, 1'b0, 8'h00);
    check("R5", gate_a20, 1'b1);
    // R6: repeated trigger stays armed
    cyc("R6", 1'b1, 1'b1, 2'd0, 1'b1, 8'hD1);
    cyc("R6", 1'b1, 1'b1, 2'd0, 1'b1, 8'hD1);
    cyc("R6", 1'b1, 1'b1, 2'd0, 1'b0, 8'h00);
    check("R6", gate_a20, 1'b0);
    // R7: other command disarms
    cyc("R7", 1'b1, 1'b1, 2'd0, 1'b1, 8'hD1);
    cyc("R7", 1'b1, 1'b1, 2'd0, 1'b1, 8'hD0);
    cyc("R7", 1'b1, 1'b1, 2'd0, 1'b0, 8'h02);
    check("R7", gate_a20, 1'b0);
    // R3: other channel, neither data nor command disturbs arming
    cyc("R3", 1'b1, 1'b1, 2'd0, 1'b1, 8'hD1);
    cyc("R3", 1'b1, 1'b1, 2'd1, 1'b0, 8'h02);
    check("R3", gate_a20, 1'b0);
    cyc("R3", 1'b1, 1'b1, 2'd3, 1'b1, 8'h55);
    // R10: idle cycle with data lines set keeps arming
    cyc("R10", 1'b1, 1'b0, 2'd0, 1'b0, 8'h02);
    check("R10", gate_a20, 1'b0);
    cyc("R3", 1'b1, 1'b1, 2'd0, 1'b0, 8'h02);
    check("R3", gate_a20, 1'b1);
    // R4: enable drop forces 1 and forgets arming
    cyc("R4", 1'b1, 1'b1, 2'd0, 1'b1, 8'hD1);
    cyc("R4", 1'b1, 1'b1, 2'd0, 1'b0, 8'h00);
    cyc("R4", 1'b1, 1'b1, 2'd0, 1'b1, 8'hD1);
    cyc("R4", 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
    check("R4", gate_a20, 1'b1);
    cyc("R4", 1'b1, 1'b1, 2'd0, 1'b0, 8'h00);
    check("R4", gate_a20, 1'b1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic       en;
      logic [7:0] d;
      en = ($urandom % 20) != 0;
      d  = (($urandom % 3) == 0) ? 8'hD1 : 8'($urandom);
      cyc("R2", en, 1'($urandom % 4 != 0), 2'($urandom % 3 == 0 ? $urandom : 0),
          1'($urandom), d);
    end
    finish_run();
  end
endmodule